// File: doc/BRIEF.md
# System control coprocessor register bank

This block is the configuration coprocessor next to a 32-bit processor core. The core sends register move requests. Each request carries a primary register number, a secondary register number, two opcode fields, a direction, a 32-bit write value, a privilege flag and a transfer kind. The block returns the read data, or an undefined-instruction flag when the access is not allowed. It holds these registers:

- two read-only identity words, chosen by the second opcode;
- a control register;
- a page table base;
- a 32-bit access-permission word covering 16 domains;
- data-side and instruction-side copies of a cache lockdown word and a TLB lockdown word;
- a 7-bit process identifier.

The block also relocates core addresses. Any address below the first 32 MB is moved into the 32 MB slot picked by the process identifier. This gives each process its own window without rewriting page tables. Cache, TLB and MMU datapaths, fault recording and test registers belong to other blocks. Requests that point at them are refused here.

Top module: `sysctl_cop`

## Requirements
- R1: For every cycle with `req_valid` high, `rsp_valid`, `rsp_rdata` and `rsp_undef` are presented exactly one clock later. `rsp_valid` is low in every other cycle.
- R2: A request with `req_priv` = 0 returns `rsp_undef` = 1 and changes no register.
- R3: `req_kind` uses these codes: 0 = register move, 1 = load/store transfer, 2 = data operation, 3 = unused. Codes 1, 2 and 3 always return `rsp_undef` = 1 and change no register.
- R4: At `req_crn` = 0 a read returns `ID_WORD` when `req_op2` = 0 and `CTYPE_WORD` when `req_op2` = 1. A write to either is accepted with `rsp_undef` = 0 and leaves the word unchanged. Any other `req_op2` returns `rsp_undef` = 1.
- R5: Positions 1 (control), 2 (table base), 3 (domains) and 13 (process ID) can be read and written when `req_op1`, `req_crm` and `req_op2` are all 0. Only these bits are stored, and all other bits read back as zero:
  - control: bits 0, 1, 2, 7, 8, 9, 12, 13, 30 and 31 (mask C0003387h);
  - table base: bits 31..14;
  - domains: all 32 bits;
  - process ID: 7 bits, held in bits 31..25.
- R6: Positions 9 (cache lockdown) and 10 (TLB lockdown) each hold two independent 32-bit words. `req_op2` = 0 selects the data side and `req_op2` = 1 selects the instruction side.
- R7: These requests return `rsp_undef` = 1 and change nothing:
  - positions 4, 11, 12 and 14, which are reserved;
  - positions 5, 6, 7, 8 and 15, which are not held here;
  - a nonzero `req_op1` or `req_crm`;
  - a nonzero `req_op2` where R5 requires 0;
  - `req_op2` greater than 1 at positions 9 and 10.
- R8: After reset, every writable register reads zero, and `rsp_valid`, `rsp_rdata`, `rsp_undef` and `mva_out` are zero.
- R9: `mva_out` follows `va_in` one clock later. When `va_in` < 02000000h the output is `va_in` + PID × 02000000h. Otherwise the output equals `va_in`. PID is the process ID held when `va_in` is sampled.
- R10: `rsp_rdata` is zero for writes and for refused requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_kind | input | 2 | Transfer kind (0 move, 1 load/store, 2 data op, 3 unused) |
| req_write | input | 1 | 1 = move to coprocessor, 0 = move from coprocessor |
| req_priv | input | 1 | Core is in a privileged mode |
| req_crn | input | 4 | Primary register position |
| req_crm | input | 4 | Secondary register number |
| req_op1 | input | 3 | First opcode field |
| req_op2 | input | 3 | Second opcode field |
| req_wdata | input | 32 | Write value |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Read value |
| rsp_undef | output | 1 | Undefined-instruction indication |
| va_in | input | 32 | Core virtual address |
| mva_out | output | 32 | Relocated address |

## Verification
Every register response is due one clock after its strobe. The bench drives each request just after a rising edge and pushes the expected word and flag into a queue. A monitor compares them at the falling edge that follows the capturing edge. After each request the driver checks that the queue has drained, so a late, early or missing response is reported under R1. Address relocation also has one clock of latency: each address is applied, one rising edge passes, and the output is sampled at the next falling edge. The process identifier used is the one written by earlier requests, which have all completed by then.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  typedef enum logic [1:0] {
    K_MOVE = 2'd0,
    K_LDST = 2'd1,
    K_DATA = 2'd2,
    K_RSVD = 2'd3
  } sc_kind_e;

  typedef enum logic [2:0] {
    RS_ID,
    RS_CTYPE,
    RS_CTRL,
    RS_TTB,
    RS_DOM,
    RS_CLOCK,
    RS_TLOCK,
    RS_PID
  } sc_sel_e;

  localparam logic [3:0] POS_IDENT = 4'd0;
  localparam logic [3:0] POS_CTRL  = 4'd1;
  localparam logic [3:0] POS_TTB   = 4'd2;
  localparam logic [3:0] POS_DOM   = 4'd3;
  localparam logic [3:0] POS_CLOCK = 4'd9;
  localparam logic [3:0] POS_TLOCK = 4'd10;
  localparam logic [3:0] POS_PID   = 4'd13;

  localparam int N_SIDES = 2;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
(
  input  logic       req_valid,
  input  logic [1:0] req_kind,
  input  logic       req_write,
  input  logic       req_priv,
  input  logic [3:0] req_crn,
  input  logic [3:0] req_crm,
  input  logic [2:0] req_op1,
  input  logic [2:0] req_op2,
  output logic       hit,
  output sc_sel_e    sel,
  output logic       side,
  output logic       wr_en
);

  logic writable;
  logic fields_ok;

  assign fields_ok = (req_kind == K_MOVE) && req_priv &&
                     (req_op1 == 3'd0) && (req_crm == 4'd0);

  always_comb begin
    hit      = 1'b0;
    sel      = RS_ID;
    side     = 1'b0;
    writable = 1'b0;
    if (fields_ok) begin
      case (req_crn)
        POS_IDENT: begin
          if (req_op2 == 3'd0) begin
            hit = 1'b1;
            sel = RS_ID;
          end else if (req_op2 == 3'd1) begin
            hit = 1'b1;
            sel = RS_CTYPE;
          end
        end
        POS_CTRL, POS_TTB, POS_DOM, POS_PID: begin
          if (req_op2 == 3'd0) begin
            hit      = 1'b1;
            writable = 1'b1;
            case (req_crn)
              POS_CTRL: sel = RS_CTRL;
              POS_TTB:  sel = RS_TTB;
              POS_DOM:  sel = RS_DOM;
              default:  sel = RS_PID;
            endcase
          end
        end
        POS_CLOCK, POS_TLOCK: begin
          if (req_op2[2:1] == 2'b00) begin
            hit      = 1'b1;
            writable = 1'b1;
            side     = req_op2[0];
            sel      = (req_crn == POS_CLOCK) ? RS_CLOCK : RS_TLOCK;
          end
        end
        default: ;
      endcase
    end
  end

  assign wr_en = req_valid && hit && req_write && writable;

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int          DW         = 32,
  parameter int          PID_W      = 7,
  parameter int          PID_LSB    = 25,
  parameter logic [31:0] ID_WORD    = 32'h5A00_1230,
  parameter logic [31:0] CTYPE_WORD = 32'h0C19_6196,
  parameter logic [31:0] CTRL_MASK  = 32'hC000_3387,
  parameter logic [31:0] TTB_MASK   = 32'hFFFF_C000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  sc_sel_e          sel,
  input  logic             side,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rd_word,
  output logic [PID_W-1:0] pid
);

  logic [DW-1:0]    ctrl_q, ttb_q, dom_q;
  logic [PID_W-1:0] pid_q;
  logic [DW-1:0]    cache_rd [N_SIDES];
  logic [DW-1:0]    tlb_rd   [N_SIDES];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      ttb_q  <= '0;
      dom_q  <= '0;
      pid_q  <= '0;
    end else if (wr_en) begin
      case (sel)
        RS_CTRL: ctrl_q <= wdata & CTRL_MASK[DW-1:0];
        RS_TTB:  ttb_q  <= wdata & TTB_MASK[DW-1:0];
        RS_DOM:  dom_q  <= wdata;
        RS_PID:  pid_q  <= wdata[PID_LSB +: PID_W];
        default: ;
      endcase
    end
  end

  for (genvar s = 0; s < N_SIDES; s++) begin : g_side
    logic [DW-1:0] cache_q, tlb_q;
    logic          hit_side;
    assign hit_side = wr_en && (side == s[0]);
    always_ff @(posedge clk) begin
      if (rst) begin
        cache_q <= '0;
        tlb_q   <= '0;
      end else if (hit_side) begin
        if (sel == RS_CLOCK) cache_q <= wdata;
        if (sel == RS_TLOCK) tlb_q   <= wdata;
      end
    end
    assign cache_rd[s] = cache_q;
    assign tlb_rd[s]   = tlb_q;
  end

  always_comb begin
    case (sel)
      RS_ID:    rd_word = ID_WORD[DW-1:0];
      RS_CTYPE: rd_word = CTYPE_WORD[DW-1:0];
      RS_CTRL:  rd_word = ctrl_q;
      RS_TTB:   rd_word = ttb_q;
      RS_DOM:   rd_word = dom_q;
      RS_CLOCK: rd_word = cache_rd[side];
      RS_TLOCK: rd_word = tlb_rd[side];
      default:  rd_word = DW'(pid_q) << PID_LSB;
    endcase
  end

  assign pid = pid_q;

  assert_pid_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && sel == RS_PID) |=> $stable(pid_q));

endmodule

// File: rtl/sysctl_fcse.sv
module sysctl_fcse #(
  parameter int DW         = 32,
  parameter int PID_W      = 7,
  parameter int SLOT_SHIFT = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PID_W-1:0] pid,
  input  logic [DW-1:0]    va_in,
  output logic [DW-1:0]    mva_out
);

  logic low_window;
  assign low_window = (va_in[DW-1:SLOT_SHIFT] == '0);

  always_ff @(posedge clk) begin
    if (rst) mva_out <= '0;
    else if (low_window) mva_out <= va_in + (DW'(pid) << SLOT_SHIFT);
    else mva_out <= va_in;
  end

  assert_pass_high_R9: assert property (@(posedge clk) disable iff (rst)
    !low_window |=> (mva_out == $past(va_in)));

  assert_pid_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (pid == '0) |=> (mva_out == $past(va_in)));

endmodule

// File: rtl/sysctl_cop.sv
module sysctl_cop
  import sysctl_pkg::*;
#(
  parameter int          DW         = 32,
  parameter int          PID_W      = 7,
  parameter int          SLOT_SHIFT = 25,
  parameter logic [31:0] ID_WORD    = 32'h5A00_1230,
  parameter logic [31:0] CTYPE_WORD = 32'h0C19_6196,
  parameter logic [31:0] CTRL_MASK  = 32'hC000_3387,
  parameter logic [31:0] TTB_MASK   = 32'hFFFF_C000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic          req_write,
  input  logic          req_priv,
  input  logic [3:0]    req_crn,
  input  logic [3:0]    req_crm,
  input  logic [2:0]    req_op1,
  input  logic [2:0]    req_op2,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_undef,
  input  logic [DW-1:0] va_in,
  output logic [DW-1:0] mva_out
);

  logic             dec_hit, dec_side, dec_wr;
  sc_sel_e          dec_sel;
  logic [DW-1:0]    rd_word;
  logic [PID_W-1:0] pid;

  sysctl_decode u_decode (
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_write (req_write),
    .req_priv  (req_priv),
    .req_crn   (req_crn),
    .req_crm   (req_crm),
    .req_op1   (req_op1),
    .req_op2   (req_op2),
    .hit       (dec_hit),
    .sel       (dec_sel),
    .side      (dec_side),
    .wr_en     (dec_wr)
  );

  sysctl_regfile #(
    .DW(DW), .PID_W(PID_W), .PID_LSB(SLOT_SHIFT),
    .ID_WORD(ID_WORD), .CTYPE_WORD(CTYPE_WORD),
    .CTRL_MASK(CTRL_MASK), .TTB_MASK(TTB_MASK)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (dec_wr),
    .sel     (dec_sel),
    .side    (dec_side),
    .wdata   (req_wdata),
    .rd_word (rd_word),
    .pid     (pid)
  );

  sysctl_fcse #(.DW(DW), .PID_W(PID_W), .SLOT_SHIFT(SLOT_SHIFT)) u_fcse (
    .clk     (clk),
    .rst     (rst),
    .pid     (pid),
    .va_in   (va_in),
    .mva_out (mva_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_undef <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_undef <= req_valid && !dec_hit;
      rsp_rdata <= (req_valid && dec_hit && !req_write) ? rd_word : '0;
    end
  end

  assert_rsp_latency_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  assert_user_undef_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_priv) |=> rsp_undef);

  assert_user_nowrite_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_priv) |-> !dec_wr);

  assert_kind_undef_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind != K_MOVE) |=> rsp_undef);

  assert_quiet_data_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_undef || !rsp_valid) |-> (rsp_rdata == '0));

endmodule

// File: tb/sysctl_cop_tb.sv
`timescale 1ns/1ps
module sysctl_cop_tb;

  localparam logic [31:0] ID_W  = 32'h5A00_1230;
  localparam logic [31:0] CT_W  = 32'h0C19_6196;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic        req_write = 1'b0;
  logic        req_priv = 1'b1;
  logic [3:0]  req_crn = '0, req_crm = '0;
  logic [2:0]  req_op1 = '0, req_op2 = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_undef;
  logic [31:0] rsp_rdata, mva_out;
  logic [31:0] va_in = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] q_data [$];
  bit          q_undef [$];
  string       q_tag [$];

  always #2.5 clk = ~clk;

  sysctl_cop u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_write(req_write), .req_priv(req_priv), .req_crn(req_crn),
    .req_crm(req_crm), .req_op1(req_op1), .req_op2(req_op2),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_undef(rsp_undef), .va_in(va_in), .mva_out(mva_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (q_data.size() == 0) begin
        check("R1 unexpected response", 32'd1, 32'd0);
      end else begin
        logic [31:0] ed;
        bit eu;
        string tg;
        ed = q_data.pop_front();
        eu = q_undef.pop_front();
        tg = q_tag.pop_front();
        check({tg, " undef"}, {31'd0, rsp_undef}, {31'd0, eu});
        check({tg, " data"}, rsp_rdata, ed);
      end
    end
  end

  task automatic do_req(input logic [1:0] kind, input bit priv, input bit wr,
                        input logic [3:0] crn, input logic [3:0] crm,
                        input logic [2:0] op1, input logic [2:0] op2,
                        input logic [31:0] wd, input logic [31:0] ed,
                        input bit eu, input string tag);
    @(posedge clk); #1;
    req_kind = kind; req_priv = priv; req_write = wr; req_crn = crn;
    req_crm = crm; req_op1 = op1; req_op2 = op2; req_wdata = wd;
    req_valid = 1'b1;
    q_data.push_back(ed); q_undef.push_back(eu); q_tag.push_back(tag);
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk); #1;
    check({"R1 drained after ", tag}, q_data.size(), 32'd0);
  endtask

  task automatic rd(input logic [3:0] crn, input logic [2:0] op2,
                    input logic [31:0] ed, input bit eu, input string tag);
    do_req(2'd0, 1'b1, 1'b0, crn, 4'd0, 3'd0, op2, 32'd0, ed, eu, tag);
  endtask

  task automatic wr(input logic [3:0] crn, input logic [2:0] op2,
                    input logic [31:0] wd, input bit eu, input string tag);
    do_req(2'd0, 1'b1, 1'b1, crn, 4'd0, 3'd0, op2, wd, 32'd0, eu, tag);
  endtask

  task automatic chk_va(input logic [31:0] va, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    va_in = va;
    @(posedge clk);
    @(negedge clk);
    check(tag, mva_out, exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R8 rsp_valid reset", {31'd0, rsp_valid}, 32'd0);
    check("R8 rsp_rdata reset", rsp_rdata, 32'd0);
    check("R8 rsp_undef reset", {31'd0, rsp_undef}, 32'd0);
    check("R8 mva_out reset", mva_out, 32'd0);
    @(posedge clk); #1 rst = 1'b0;

    rd(4'd1, 3'd0, 32'd0, 0, "R8 ctrl zero");
    rd(4'd2, 3'd0, 32'd0, 0, "R8 ttb zero");
    rd(4'd3, 3'd0, 32'd0, 0, "R8 dom zero");
    rd(4'd13, 3'd0, 32'd0, 0, "R8 pid zero");
    rd(4'd9, 3'd0, 32'd0, 0, "R8 cache lock d zero");
    rd(4'd9, 3'd1, 32'd0, 0, "R8 cache lock i zero");
    rd(4'd10, 3'd0, 32'd0, 0, "R8 tlb lock d zero");
    rd(4'd10, 3'd1, 32'd0, 0, "R8 tlb lock i zero");

    rd(4'd0, 3'd0, ID_W, 0, "R4 id word");
    rd(4'd0, 3'd1, CT_W, 0, "R4 cache type word");
    rd(4'd0, 3'd2, 32'd0, 1, "R4 bad op2 at pos0");
    wr(4'd0, 3'd0, 32'hFFFF_FFFF, 0, "R10 write id ignored");
    wr(4'd0, 3'd1, 32'h0000_0000, 0, "R4 write ctype ignored");
    rd(4'd0, 3'd0, ID_W, 0, "R4 id unchanged");
    rd(4'd0, 3'd1, CT_W, 0, "R4 ctype unchanged");

    wr(4'd1, 3'd0, 32'hFFFF_FFFF, 0, "R10 ctrl write");
    rd(4'd1, 3'd0, 32'hC000_3387, 0, "R5 ctrl mask");
    wr(4'd2, 3'd0, 32'h1234_5678, 0, "R5 ttb write");
    rd(4'd2, 3'd0, 32'h1234_4000, 0, "R5 ttb mask");
    wr(4'd3, 3'd0, 32'hA5A5_5A5A, 0, "R5 dom write");
    rd(4'd3, 3'd0, 32'hA5A5_5A5A, 0, "R5 dom read");
    wr(4'd13, 3'd0, 32'hFFFF_FFFF, 0, "R5 pid write");
    rd(4'd13, 3'd0, 32'hFE00_0000, 0, "R5 pid read");

    wr(4'd9, 3'd0, 32'h1111_0000, 0, "R6 cache d write");
    wr(4'd9, 3'd1, 32'h2222_0000, 0, "R6 cache i write");
    wr(4'd10, 3'd0, 32'h3333_0000, 0, "R6 tlb d write");
    wr(4'd10, 3'd1, 32'h4444_0000, 0, "R6 tlb i write");
    rd(4'd9, 3'd0, 32'h1111_0000, 0, "R6 cache d read");
    rd(4'd9, 3'd1, 32'h2222_0000, 0, "R6 cache i read");
    rd(4'd10, 3'd0, 32'h3333_0000, 0, "R6 tlb d read");
    rd(4'd10, 3'd1, 32'h4444_0000, 0, "R6 tlb i read");
    rd(4'd9, 3'd2, 32'd0, 1, "R7 lock op2 two");

    do_req(2'd0, 1'b0, 1'b0, 4'd1, 4'd0, 3'd0, 3'd0, 32'd0, 32'd0, 1, "R2 user read");
    do_req(2'd0, 1'b0, 1'b1, 4'd1, 4'd0, 3'd0, 3'd0, 32'd0, 32'd0, 1, "R2 user write");
    do_req(2'd0, 1'b0, 1'b1, 4'd9, 4'd0, 3'd0, 3'd1, 32'd0, 32'd0, 1, "R2 user lock write");
    rd(4'd1, 3'd0, 32'hC000_3387, 0, "R2 ctrl kept");
    rd(4'd9, 3'd1, 32'h2222_0000, 0, "R2 lock kept");

    do_req(2'd1, 1'b1, 1'b0, 4'd1, 4'd0, 3'd0, 3'd0, 32'd0, 32'd0, 1, "R3 load store");
    do_req(2'd2, 1'b1, 1'b1, 4'd3, 4'd0, 3'd0, 3'd0, 32'd0, 32'd0, 1, "R3 data op");
    do_req(2'd3, 1'b1, 1'b1, 4'd3, 4'd0, 3'd0, 3'd0, 32'd0, 32'd0, 1, "R3 unused kind");
    rd(4'd3, 3'd0, 32'hA5A5_5A5A, 0, "R3 dom kept");

    rd(4'd4, 3'd0, 32'd0, 1, "R7 pos4");
    rd(4'd11, 3'd0, 32'd0, 1, "R7 pos11");
    rd(4'd12, 3'd0, 32'd0, 1, "R7 pos12");
    rd(4'd14, 3'd0, 32'd0, 1, "R7 pos14");
    rd(4'd7, 3'd0, 32'd0, 1, "R7 pos7");
    rd(4'd15, 3'd0, 32'd0, 1, "R7 pos15");
    rd(4'd1, 3'd1, 32'd0, 1, "R7 ctrl op2 one");
    do_req(2'd0, 1'b1, 1'b0, 4'd1, 4'd1, 3'd0, 3'd0, 32'd0, 32'd0, 1, "R7 crm nonzero");
    do_req(2'd0, 1'b1, 1'b0, 4'd1, 4'd0, 3'd1, 3'd0, 32'd0, 32'd0, 1, "R7 op1 nonzero");
    do_req(2'd0, 1'b1, 1'b1, 4'd2, 4'd1, 3'd0, 3'd0, 32'hFFFF_FFFF, 32'd0, 1, "R7 ttb crm write");
    rd(4'd2, 3'd0, 32'h1234_4000, 0, "R7 ttb kept");

    chk_va(32'h0000_1000, 32'hFE00_1000, "R9 low with pid 7f");
    chk_va(32'h01FF_FFFF, 32'hFFFF_FFFF, "R9 top of window");
    chk_va(32'h0200_0000, 32'h0200_0000, "R9 boundary passes");
    chk_va(32'h8765_4321, 32'h8765_4321, "R9 high passes");
    wr(4'd13, 3'd0, 32'h0600_0000, 0, "R9 pid three");
    chk_va(32'h0000_0010, 32'h0600_0010, "R9 low with pid 3");
    wr(4'd13, 3'd0, 32'h0000_0000, 0, "R9 pid zero");
    chk_va(32'h0123_4567, 32'h0123_4567, "R9 pid zero passes");

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 queue empty at end", q_data.size(), 32'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule